// File: doc/BRIEF.md
# Multi-Context Write-DMA Frame Event Generator

This block sits beside a multi-context write DMA and turns what it observes into interrupt events. It taps the tagged word stream entering the DMA. Each word carries a context number, a 4-bit tag, an end-of-line flag and a flag saying the cropping stage threw the word away. It also taps the strobe the DMA raises each time it issues a memory write request. Each context gets three events: frame start, frame end and circular line count. One further event fires when a chosen context reaches a chosen line.

Events land in a sticky status register. Software clears a status bit by writing 1 to it. An enable register has separate set and clear strobes. The registered OR of the enabled status bits drives a single interrupt line.

The monitored stream is a valid/ready channel owned by the DMA. This block never drives ready and never applies back-pressure. It treats a word as transferred only in a cycle where `mon_valid` and `mon_ready` are both high. A word held with valid high and ready low is seen once, when it finally transfers. Control and status pins are plain levels or one-cycle strobes.

Top module: `dma_evt_gen`

## Requirements
- R1: During and after reset `status`, `enable` and `irq` are 0. `hw_ctx_count` always reads NUM_CTX.
- R2: A stream word has an effect only in a cycle where `mon_valid` and `mon_ready` are both 1. A word offered with ready low changes nothing.
- R3: A transferred word with tag code 1, 2, 3, 4 or 5 sets status bit `c`, where `c` is `mon_ctx`. The five codes are attribute header start, attribute data start, control header start, pixel header start and pixel frame start. The bit is set at the same clock edge that transfers the word. Code 0 (payload) and codes 12 to 15 raise no event.
- R4: Tag codes 6 to 11 are the end tags: attribute header end, attribute data end, control header end, pixel header end, pixel frame end and frame-end code. Frame end sets status bit `NUM_CTX+c` once two things hold for context `c`:
  - an end tag for `c` has arrived;
  - every kept end-of-line word of `c` has been matched by an issued line-final write request (`wr_issue` and `wr_line_end` both high, with `wr_ctx`=`c`).
  The bit is set one clock edge after the later of the two. The block does not wait for any write response.
- R5: If the end tag word was discarded (`mon_drop`=1) and the earlier kept lines already have their requests, frame end fires one edge later with no further write request.
- R6: A circular event sets status bit `2*NUM_CTX+c` at every (4 << mode)-th line-final write request of context `c`. The 2-bit mode for context `c` is `cfg_circ_mode[2c+1:2c]`, so codes 0 to 3 give 4, 8, 16 or 32 lines. A frame-start word for `c` restarts the count.
- R7: The line event sets status bit `3*NUM_CTX` when an end-of-line word transfers on context `cfg_line_port` and the number of end-of-line words that context has had since its last frame start equals `cfg_line_idx`. A port value of NUM_CTX or above never fires.
- R8: Status bits stay set until a 1 is written to the bit on `st_clr`. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R9: An `en_set` bit sets that enable bit, and an `en_clr` bit clears it. If both hit the same bit in the same cycle, the bit ends up set.
- R10: `irq` is the OR of `status & enable` as it was one edge earlier. Status bits update whether or not they are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_valid | input | 1 | Monitored stream: word valid |
| mon_ready | input | 1 | Monitored stream: DMA accepts word |
| mon_ctx | input | CTX_W | Context number of the word |
| mon_tag | input | 4 | Tag code of the word |
| mon_eol | input | 1 | Word closes a line |
| mon_drop | input | 1 | Word discarded by cropping |
| wr_issue | input | 1 | A memory write request is issued this cycle |
| wr_line_end | input | 1 | Issued request is the last one of a line |
| wr_ctx | input | CTX_W | Context of the issued request |
| cfg_circ_mode | input | 2*NUM_CTX | Circular line-count code per context |
| cfg_line_idx | input | LINE_W | Target line number |
| cfg_line_port | input | PORT_W | Context watched for the line event |
| st_clr | input | STAT_W | Write-1-to-clear strobe for status |
| en_set | input | STAT_W | Enable set strobe |
| en_clr | input | STAT_W | Enable clear strobe |
| status | output | STAT_W | Sticky event status |
| enable | output | STAT_W | Event enable mask |
| irq | output | 1 | Merged interrupt |
| hw_ctx_count | output | 6 | Number of contexts built in |

## Verification
The bound checker watches several properties on every cycle:
- status bits never drop except under a clear strobe;
- `irq` always matches the previous cycle's enabled status;
- enable set strobes always take effect;
- a start or circular status bit only rises just after a matching transferred word or line-final write request.

The bench scenarios cover the ordering-dependent behaviour that a one-cycle property cannot state:
- frame end held back until the last line-final request, or released early for a discarded tail;
- circular counts across several modes and a mid-count restart;
- the line event on a selected and on an out-of-range port;
- the event-over-clear and set-over-clear collisions.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;

  localparam int TAG_W = 4;

  typedef enum logic [TAG_W-1:0] {
    TG_PAYLOAD = 4'd0,
    TG_ATTR_HS = 4'd1,
    TG_ATTR_DS = 4'd2,
    TG_CTRL_HS = 4'd3,
    TG_PIXH_S  = 4'd4,
    TG_PIX_FS  = 4'd5,
    TG_ATTR_HE = 4'd6,
    TG_ATTR_DE = 4'd7,
    TG_CTRL_HE = 4'd8,
    TG_PIXH_E  = 4'd9,
    TG_PIX_FE  = 4'd10,
    TG_FE_CODE = 4'd11
  } tag_e;

  // Tag opens a header, packet or frame.
  function automatic logic tag_opens(input logic [TAG_W-1:0] t);
    case (tag_e'(t))
      TG_ATTR_HS, TG_ATTR_DS, TG_CTRL_HS, TG_PIXH_S, TG_PIX_FS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Tag closes a header, packet or frame.
  function automatic logic tag_closes(input logic [TAG_W-1:0] t);
    case (tag_e'(t))
      TG_ATTR_HE, TG_ATTR_DE, TG_CTRL_HE, TG_PIXH_E, TG_PIX_FE, TG_FE_CODE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Lines per circular event for a 2-bit mode code.
  function automatic logic [5:0] circ_lines(input logic [1:0] m);
    return 6'd4 << m;
  endfunction

endpackage

// File: rtl/dma_evt_ctx.sv
module dma_evt_ctx
  import dma_evt_pkg::*;
#(
  parameter int LINE_W = 14,
  parameter int OWE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [TAG_W-1:0]  tag,
  input  logic              eol,
  input  logic              drop,
  input  logic              wr_done,
  input  logic [1:0]        circ_mode,
  output logic              ev_start,
  output logic              ev_end,
  output logic              ev_circ,
  output logic              eol_hit,
  output logic [LINE_W-1:0] line_base
);

  logic              opens, closes, kept_eol, wr_take, circ_wrap;
  logic [OWE_W-1:0]  owed;
  logic              end_pend;
  logic [LINE_W-1:0] line_cnt;
  logic [5:0]        circ_cnt;

  assign opens     = acc && tag_opens(tag);
  assign closes    = acc && tag_closes(tag);
  assign kept_eol  = acc && eol && !drop;
  assign wr_take   = wr_done && (owed != '0);
  assign circ_wrap = (circ_cnt + 6'd1) == circ_lines(circ_mode);

  assign ev_start  = opens;
  assign ev_end    = end_pend && (owed == '0);
  assign ev_circ   = wr_done && !opens && circ_wrap;
  assign eol_hit   = acc && eol;
  assign line_base = opens ? '0 : line_cnt;

  // Kept lines still waiting for their line-final write request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed <= '0;
    end else begin
      case ({kept_eol, wr_take})
        2'b10:   owed <= owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  // End tag seen, frame end not yet reported.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      end_pend <= 1'b0;
    else if (closes) end_pend <= 1'b1;
    else if (ev_end) end_pend <= 1'b0;
  end

  // Lines received since the last frame start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           line_cnt <= '0;
    else if (opens)       line_cnt <= eol ? LINE_W'(1) : '0;
    else if (acc && eol)  line_cnt <= line_cnt + 1'b1;
  end

  // Line-final write requests within the current circular window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        circ_cnt <= '0;
    else if (opens)    circ_cnt <= '0;
    else if (wr_done)  circ_cnt <= circ_wrap ? 6'd0 : circ_cnt + 6'd1;
  end

endmodule

// File: rtl/dma_evt_linehit.sv
module dma_evt_linehit #(
  parameter int NUM_CTX = 4,
  parameter int LINE_W  = 14,
  parameter int PORT_W  = 5
) (
  input  logic [NUM_CTX-1:0]        eol_hit,
  input  logic [NUM_CTX*LINE_W-1:0] line_base,
  input  logic [LINE_W-1:0]         target,
  input  logic [PORT_W-1:0]         port,
  output logic                      hit
);

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (port == PORT_W'(i) && eol_hit[i] &&
          line_base[i*LINE_W +: LINE_W] == target)
        hit = 1'b1;
    end
  end

endmodule

// File: rtl/dma_evt_irqreg.sv
module dma_evt_irqreg #(
  parameter int STAT_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] ev,
  input  logic [STAT_W-1:0] st_clr,
  input  logic [STAT_W-1:0] en_set,
  input  logic [STAT_W-1:0] en_clr,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] enable,
  output logic              irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~st_clr) | ev;
      enable <= (enable & ~en_clr) | en_set;
      irq    <= |(status & enable);
    end
  end

endmodule

// File: rtl/dma_evt_gen.sv
module dma_evt_gen
  import dma_evt_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int LINE_W  = 14,
  parameter int PORT_W  = 5,
  parameter int OWE_W   = 4,
  localparam int CTX_W  = $clog2(NUM_CTX),
  localparam int STAT_W = 3 * NUM_CTX + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mon_valid,
  input  logic                   mon_ready,
  input  logic [CTX_W-1:0]       mon_ctx,
  input  logic [TAG_W-1:0]       mon_tag,
  input  logic                   mon_eol,
  input  logic                   mon_drop,
  input  logic                   wr_issue,
  input  logic                   wr_line_end,
  input  logic [CTX_W-1:0]       wr_ctx,
  input  logic [2*NUM_CTX-1:0]   cfg_circ_mode,
  input  logic [LINE_W-1:0]      cfg_line_idx,
  input  logic [PORT_W-1:0]      cfg_line_port,
  input  logic [STAT_W-1:0]      st_clr,
  input  logic [STAT_W-1:0]      en_set,
  input  logic [STAT_W-1:0]      en_clr,
  output logic [STAT_W-1:0]      status,
  output logic [STAT_W-1:0]      enable,
  output logic                   irq,
  output logic [5:0]             hw_ctx_count
);

  logic                      xfer;
  logic [NUM_CTX-1:0]        ev_start, ev_end, ev_circ, eol_hit;
  logic [NUM_CTX*LINE_W-1:0] line_base;
  logic                      line_ev;
  logic [STAT_W-1:0]         ev;

  assign xfer         = mon_valid && mon_ready;
  assign hw_ctx_count = 6'(NUM_CTX);

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    dma_evt_ctx #(.LINE_W(LINE_W), .OWE_W(OWE_W)) u_ctx (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (xfer && mon_ctx == CTX_W'(c)),
      .tag       (mon_tag),
      .eol       (mon_eol),
      .drop      (mon_drop),
      .wr_done   (wr_issue && wr_line_end && wr_ctx == CTX_W'(c)),
      .circ_mode (cfg_circ_mode[2*c +: 2]),
      .ev_start  (ev_start[c]),
      .ev_end    (ev_end[c]),
      .ev_circ   (ev_circ[c]),
      .eol_hit   (eol_hit[c]),
      .line_base (line_base[c*LINE_W +: LINE_W])
    );
  end

  dma_evt_linehit #(.NUM_CTX(NUM_CTX), .LINE_W(LINE_W), .PORT_W(PORT_W)) u_line (
    .eol_hit   (eol_hit),
    .line_base (line_base),
    .target    (cfg_line_idx),
    .port      (cfg_line_port),
    .hit       (line_ev)
  );

  assign ev = {line_ev, ev_circ, ev_end, ev_start};

  dma_evt_irqreg #(.STAT_W(STAT_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (ev),
    .st_clr (st_clr),
    .en_set (en_set),
    .en_clr (en_clr),
    .status (status),
    .enable (enable),
    .irq    (irq)
  );

endmodule

// File: rtl/dma_evt_gen_chk.sv
module dma_evt_gen_chk #(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2,
  parameter int STAT_W  = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mon_valid,
  input logic              mon_ready,
  input logic [CTX_W-1:0]  mon_ctx,
  input logic [3:0]        mon_tag,
  input logic              wr_issue,
  input logic              wr_line_end,
  input logic [CTX_W-1:0]  wr_ctx,
  input logic [STAT_W-1:0] st_clr,
  input logic [STAT_W-1:0] en_set,
  input logic [STAT_W-1:0] status,
  input logic [STAT_W-1:0] enable,
  input logic              irq
);

  // R8
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(status) & ~$past(st_clr)) & ~status) == '0));

  // R10
  irq_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |($past(status) & $past(enable)));

  // R9
  enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((enable & $past(en_set)) == $past(en_set)));

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_chk
    // R2 R3
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[i]) |-> $past(mon_valid && mon_ready && mon_ctx == CTX_W'(i) &&
                                 mon_tag >= 4'd1 && mon_tag <= 4'd5));
    // R6
    circ_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[2*NUM_CTX+i]) |-> $past(wr_issue && wr_line_end && wr_ctx == CTX_W'(i)));
  end

endmodule

bind dma_evt_gen dma_evt_gen_chk #(
  .NUM_CTX (NUM_CTX),
  .CTX_W   (CTX_W),
  .STAT_W  (STAT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mon_valid   (mon_valid),
  .mon_ready   (mon_ready),
  .mon_ctx     (mon_ctx),
  .mon_tag     (mon_tag),
  .wr_issue    (wr_issue),
  .wr_line_end (wr_line_end),
  .wr_ctx      (wr_ctx),
  .st_clr      (st_clr),
  .en_set      (en_set),
  .status      (status),
  .enable      (enable),
  .irq         (irq)
);

// File: tb/dma_evt_gen_test.sv
module dma_evt_gen_test;

  localparam int N  = 4;
  localparam int CW = 2;
  localparam int SW = 3 * N + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mon_valid = 1'b0, mon_ready = 1'b0, mon_eol = 1'b0, mon_drop = 1'b0;
  logic [CW-1:0] mon_ctx = '0;
  logic [3:0]    mon_tag = '0;
  logic          wr_issue = 1'b0, wr_line_end = 1'b0;
  logic [CW-1:0] wr_ctx = '0;
  logic [2*N-1:0] cfg_circ_mode = 8'h04;
  logic [13:0]   cfg_line_idx = '0;
  logic [4:0]    cfg_line_port = '0;
  logic [SW-1:0] st_clr = '0, en_set = '0, en_clr = '0;
  logic [SW-1:0] status, enable;
  logic          irq;
  logic [5:0]    hw_ctx_count;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dma_evt_gen #(.NUM_CTX(N)) uut (
    .clk(clk), .rst_n(rst_n), .mon_valid(mon_valid), .mon_ready(mon_ready),
    .mon_ctx(mon_ctx), .mon_tag(mon_tag), .mon_eol(mon_eol), .mon_drop(mon_drop),
    .wr_issue(wr_issue), .wr_line_end(wr_line_end), .wr_ctx(wr_ctx),
    .cfg_circ_mode(cfg_circ_mode), .cfg_line_idx(cfg_line_idx), .cfg_line_port(cfg_line_port),
    .st_clr(st_clr), .en_set(en_set), .en_clr(en_clr),
    .status(status), .enable(enable), .irq(irq), .hw_ctx_count(hw_ctx_count)
  );

  typedef struct {
    logic [SW-1:0] st;
    bit            use_irq;
    logic          irq_v;
    string         req;
  } item_t;

  item_t q[$];
  event  push_ev;

  // Scoreboard monitor
  initial begin
    forever begin
      @(push_ev);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (status !== it.st) begin
          n_fail++;
          $display("FAIL %s: status=%h expected %h", it.req, status, it.st);
        end
        if (it.use_irq) begin
          n_chk++;
          if (irq !== it.irq_v) begin
            n_fail++;
            $display("FAIL %s: irq=%b expected %b", it.req, irq, it.irq_v);
          end
        end
      end
    end
  end

  task automatic exp_st(input logic [SW-1:0] st, input bit ui, input logic iv, input string r);
    item_t it;
    it.st = st; it.use_irq = ui; it.irq_v = iv; it.req = r;
    q.push_back(it);
    -> push_ev;
    #1;
  endtask

  task automatic chk_val(input logic [31:0] act, input logic [31:0] expv, input string r);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", r, act, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic word(input int c, input int t, input bit e, input bit d, input bit rdy = 1'b1);
    mon_valid = 1'b1; mon_ready = rdy; mon_ctx = CW'(c);
    mon_tag = 4'(t); mon_eol = e; mon_drop = d;
    @(negedge clk);
    mon_valid = 1'b0; mon_ready = 1'b0; mon_eol = 1'b0; mon_drop = 1'b0; mon_tag = '0;
  endtask

  task automatic wrl(input int c);
    wr_issue = 1'b1; wr_line_end = 1'b1; wr_ctx = CW'(c);
    @(negedge clk);
    wr_issue = 1'b0; wr_line_end = 1'b0;
  endtask

  task automatic clr_all;
    st_clr = '1;
    @(negedge clk);
    st_clr = '0;
  endtask

  // Watchdog
  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset state
    exp_st('0, 1, 1'b0, "R1 status in reset");
    chk_val(32'(enable), 0, "R1 enable in reset");
    chk_val(32'(hw_ctx_count), N, "R1 hw_ctx_count");
    rst_n = 1'b1;
    idle(2);
    exp_st('0, 1, 1'b0, "R1 after reset");

    // R2 start offered with ready low is ignored
    word(1, 5, 0, 0, 1'b0);
    exp_st('0, 0, 1'b0, "R2 ready low");

    // R3 start codes set per-context bits; R10 status visible while disabled
    word(1, 5, 0, 0);
    exp_st(13'h0002, 1, 1'b0, "R3 pixel frame start ctx1 / R10 no irq");
    word(0, 1, 0, 0);
    word(2, 2, 0, 0);
    word(3, 3, 0, 0);
    word(0, 4, 0, 0);
    exp_st(13'h000F, 0, 1'b0, "R3 codes 1-4");
    word(2, 0, 0, 0);
    word(3, 12, 0, 0);
    exp_st(13'h000F, 0, 1'b0, "R3 payload and code 12 no event");
    clr_all();
    exp_st('0, 0, 1'b0, "R8 write-1 clear");

    // R9 / R10 enable and irq
    en_set = 13'h0002; idle(1); en_set = '0;
    chk_val(32'(enable), 32'h2, "R9 enable set");
    word(1, 5, 0, 0);
    exp_st(13'h0002, 1, 1'b0, "R10 irq lags status");
    idle(1);
    exp_st(13'h0002, 1, 1'b1, "R10 irq asserted");
    en_clr = 13'h0002; idle(1); en_clr = '0;
    chk_val(32'(enable), 32'h0, "R9 enable clear");
    idle(1);
    exp_st(13'h0002, 1, 1'b0, "R10 irq drops after disable");
    en_set = 13'h0002; en_clr = 13'h0002; idle(1); en_set = '0; en_clr = '0;
    chk_val(32'(enable), 32'h2, "R9 set wins over clear");
    en_clr = 13'h0002; idle(1); en_clr = '0;

    // R8 event wins over clear
    st_clr = 13'h0002;
    word(1, 5, 0, 0);
    st_clr = '0;
    exp_st(13'h0002, 0, 1'b0, "R8 event beats clear");
    clr_all();
    exp_st('0, 0, 1'b0, "R8 clear");

    // R4 frame end waits for last line-final request
    word(2, 5, 0, 0);
    word(2, 0, 1, 0);
    word(2, 10, 1, 0);
    idle(2);
    exp_st(13'h0004, 0, 1'b0, "R4 no end before requests");
    wrl(2);
    idle(1);
    exp_st(13'h0004, 0, 1'b0, "R4 one request outstanding");
    wrl(2);
    exp_st(13'h0004, 0, 1'b0, "R4 end one edge after last request");
    idle(1);
    exp_st(13'h0044, 0, 1'b0, "R4 frame end ctx2");
    clr_all();

    // R5 discarded tail
    word(3, 1, 0, 0);
    word(3, 0, 1, 0);
    wrl(3);
    word(3, 11, 1, 1);
    idle(1);
    exp_st(13'h0088, 0, 1'b0, "R5 end with dropped tail");
    clr_all();

    // R6 circular events: ctx0 mode 0 (4 lines), ctx1 mode 1 (8 lines)
    for (int k = 0; k < 3; k++) wrl(0);
    exp_st('0, 0, 1'b0, "R6 three lines no event");
    wrl(0);
    exp_st(13'h0100, 0, 1'b0, "R6 fourth line ctx0");
    clr_all();
    for (int k = 0; k < 7; k++) wrl(1);
    exp_st('0, 0, 1'b0, "R6 seven lines mode1");
    wrl(1);
    exp_st(13'h0200, 0, 1'b0, "R6 eighth line ctx1");
    clr_all();
    wrl(0);
    wrl(0);
    word(0, 5, 0, 0);
    for (int k = 0; k < 3; k++) wrl(0);
    exp_st(13'h0001, 0, 1'b0, "R6 start restarts count");
    wrl(0);
    exp_st(13'h0101, 0, 1'b0, "R6 event after restart");
    clr_all();

    // R7 line number event
    cfg_line_port = 5'd2; cfg_line_idx = 14'd3;
    word(2, 5, 0, 0);
    for (int k = 0; k < 3; k++) word(2, 0, 1, 0);
    exp_st(13'h0004, 0, 1'b0, "R7 before target line");
    word(2, 0, 1, 0);
    exp_st(13'h1004, 0, 1'b0, "R7 target line reached");
    clr_all();
    cfg_line_port = 5'd7;
    word(2, 5, 0, 0);
    for (int k = 0; k < 5; k++) word(2, 0, 1, 0);
    exp_st(13'h0004, 0, 1'b0, "R7 out-of-range port silent");

    // R10 merge of all enabled bits
    en_set = '1; idle(1); en_set = '0;
    idle(1);
    exp_st(13'h0004, 1, 1'b1, "R10 merged irq");
    clr_all();
    idle(1);
    exp_st('0, 1, 1'b0, "R10 irq clears");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule